// File: doc/BRIEF.md
# Boundary-Scan Data Register with Tristate-Group Enable Cells

This block is the boundary-scan data register of a small device. It sits between the device pins and the core logic. It holds one scan cell per input pin and one per output pin. It also holds one extra cell per tristate output group, which sets whether that group drives. Every cell has a shift stage, clocked on the rising test clock, and an update register, loaded on the falling test clock. The capture, shift and update strobes come already decoded from a TAP controller outside the block. The same controller supplies the one-hot instruction flags: external test, internal test, sample/preload and high-impedance.

In normal operation the pins feed the core and the core drives the pins and their enables. A sample/preload instruction can capture that traffic into the chain, or load guard values into the chain without disturbing the device. The guard values are loaded before a test instruction is selected. Under either test instruction the update registers take over the core inputs, the pin outputs and the group enables. This lets test vectors be applied to the board, or applied to the core one step at a time. Under the high-impedance instruction every group stops driving.

The interface is a set of plain strobes and levels. The data path is a serial stream clocked by the test clock, so there is no valid/ready handshake. The serial stream has no back-pressure: a bit moves on every rising edge while the shift strobe is high and the register is selected. At most one instruction flag may be high at a time.

Top module: `bscan_reg`

## Requirements
- R1: The chain has N_IN + N_GRP*(GRP_W+1) cells. Cell 0 is next to `tdi`. Cells 0..N_IN-1 are the input-pin cells, in pin order. After them come N_GRP sections in group order. Each section is the group's enable cell followed by its GRP_W output cells, in pin order. A rising `tck` with `shift_dr` high and a chain-selecting instruction (external test, internal test or sample) moves every shift stage one cell toward `tdo`. `tdi` enters cell 0. `tdo` shows the shift stage of the last cell.
- R2: A rising `tck` with `cap_dr` high and a chain-selecting instruction loads the shift stages. Input cells load `pin_in`. Output cells load `core_out` under sample or internal test, and load their own update register under external test.
- R3: Update registers load from the shift stages on a falling `tck` with `upd_dr` high and a chain-selecting instruction. At all other times they hold their value.
- R4: Under external or internal test, `core_in` equals the input cells' update registers, and `pin_in` has no effect on it.
- R5: Under external or internal test, `pin_out` equals the output cells' update registers, and `core_out` has no effect on it.
- R6: Bit g of GRP_POL sets the disable level of group g's enable cell: 1 means a 1 disables, 0 means a 0 disables. Under a test instruction, `pin_oe[g]` (1 = group drives) is 0 exactly when the enable cell's update register holds the disable level.
- R7: Under the high-impedance instruction, `pin_oe` is all zero whatever the register contents.
- R8: With no test and no high-impedance instruction, `core_in` = `pin_in` and `pin_out` = `core_out`. `pin_oe[g]` is 0 exactly when `core_dis[g]` equals the disable level of group g.
- R9: A capture under sample or internal test loads each enable cell with the core's disable signal `core_dis[g]` as driven, so a core disabling a 1-disables group is read back as 1.
- R10: Two events set every shift stage and update register to the guard value: `trst_n` low (asynchronous), and `tlr` high on a clock edge. The guard value is the disable level in each enable cell and 0 in every other cell. So under a test instruction after reset every group is off.
- R11: With no chain-selecting instruction (bypass, high-impedance or idle), the capture, shift and update strobes leave the register unchanged.
- R12: When `cap_dr` and `shift_dr` are both high, capture wins. `tlr` wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr | input | 1 | TAP is in its test-logic-reset state |
| cap_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| upd_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| ir_extest | input | 1 | External test instruction selected |
| ir_intest | input | 1 | Internal test instruction selected |
| ir_sample | input | 1 | Sample/preload instruction selected |
| ir_highz | input | 1 | High-impedance instruction selected |
| pin_in | input | N_IN | Values at the input pins |
| core_in | output | N_IN | Values presented to the core inputs |
| core_out | input | N_GRP*GRP_W | Core output data, group-major |
| core_dis | input | N_GRP | Core disable level per group, in that group's polarity |
| pin_out | output | N_GRP*GRP_W | Data driven to the output pins |
| pin_oe | output | N_GRP | Group drive enable, 1 = driving |
| tdo | output | 1 | Serial data out |

## Verification
Each kind of fault in a shift stage shows up at a different time and place. A wrong shift stage reaches `tdo` after at most the chain length of shift edges. It also reaches the captured read-back after a single capture and scan. A wrong update register shows up under a test instruction in the very cycle after the falling edge that loaded it, on `core_in`, `pin_out` or `pin_oe`. A polarity or high-impedance fault shows on `pin_oe` combinationally within that cycle. The bench therefore compares every output against its model on every clock, so a divergence is reported within one cycle of reaching a port.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  // Position of group g's enable cell in the chain (0 = next to tdi)
  function automatic int en_idx(input int g, input int n_in, input int gw);
    return n_in + g * (gw + 1);
  endfunction

  // Position of output pin p's cell; pins are numbered group-major
  function automatic int out_idx(input int p, input int n_in, input int gw);
    return en_idx(p / gw, n_in, gw) + 1 + (p % gw);
  endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell #(
  parameter logic RST = 1'b0
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tlr,
  input  logic cap_en,
  input  logic sh_en,
  input  logic upd_en,
  input  logic cap_d,
  input  logic si,
  output logic sh_q,
  output logic up_q
);

  // Shift stage: rising edge, capture beats shift
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     sh_q <= RST;
    else if (tlr)    sh_q <= RST;
    else if (cap_en) sh_q <= cap_d;
    else if (sh_en)  sh_q <= si;
  end

  // Update register: falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     up_q <= RST;
    else if (tlr)    up_q <= RST;
    else if (upd_en) up_q <= sh_q;
  end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int         L     = 12,
  parameter logic [L-1:0] GUARD = '0
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tlr,
  input  logic         cap_en,
  input  logic         sh_en,
  input  logic         upd_en,
  input  logic         tdi,
  input  logic [L-1:0] cap_d,
  output logic [L-1:0] sh_q,
  output logic [L-1:0] up_q,
  output logic         tdo
);

  logic [L-1:0] si;
  assign si  = {sh_q[L-2:0], tdi};
  assign tdo = sh_q[L-1];

  for (genvar i = 0; i < L; i++) begin : g_cell
    bscan_cell #(.RST(GUARD[i])) cell_i (
      .tck    (tck),
      .trst_n (trst_n),
      .tlr    (tlr),
      .cap_en (cap_en),
      .sh_en  (sh_en),
      .upd_en (upd_en),
      .cap_d  (cap_d[i]),
      .si     (si[i]),
      .sh_q   (sh_q[i]),
      .up_q   (up_q[i])
    );
  end

endmodule

// File: rtl/bscan_route.sv
module bscan_route
  import bscan_pkg::*;
#(
  parameter int               N_IN    = 4,
  parameter int               N_GRP   = 2,
  parameter int               GRP_W   = 3,
  parameter logic [N_GRP-1:0] GRP_POL = '0,
  localparam int              N_OUT   = N_GRP * GRP_W,
  localparam int              L       = N_IN + N_GRP * (GRP_W + 1)
) (
  input  logic             ir_extest,
  input  logic             ir_intest,
  input  logic             ir_highz,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_GRP-1:0] core_dis,
  input  logic [L-1:0]     up_q,
  output logic [N_IN-1:0]  core_in,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_GRP-1:0] pin_oe,
  output logic [L-1:0]     cap_d
);

  logic test;
  assign test = ir_extest | ir_intest;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    assign core_in[i] = test ? up_q[i] : pin_in[i];
    assign cap_d[i]   = pin_in[i];
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int EI = en_idx(g, N_IN, GRP_W);
    logic dis_lvl;
    assign dis_lvl   = test ? up_q[EI] : core_dis[g];
    assign pin_oe[g] = !ir_highz && (dis_lvl != GRP_POL[g]);
    assign cap_d[EI] = ir_extest ? up_q[EI] : core_dis[g];

    for (genvar j = 0; j < GRP_W; j++) begin : g_bit
      localparam int P  = g * GRP_W + j;
      localparam int OI = out_idx(P, N_IN, GRP_W);
      assign pin_out[P] = test ? up_q[OI] : core_out[P];
      assign cap_d[OI]  = ir_extest ? up_q[OI] : core_out[P];
    end
  end

endmodule

// File: rtl/bscan_reg.sv
module bscan_reg
  import bscan_pkg::*;
#(
  parameter int               N_IN    = 4,
  parameter int               N_GRP   = 2,
  parameter int               GRP_W   = 3,
  parameter logic [N_GRP-1:0] GRP_POL = 2'b10
) (
  input  logic                     tck,
  input  logic                     trst_n,
  input  logic                     tlr,
  input  logic                     cap_dr,
  input  logic                     shift_dr,
  input  logic                     upd_dr,
  input  logic                     tdi,
  input  logic                     ir_extest,
  input  logic                     ir_intest,
  input  logic                     ir_sample,
  input  logic                     ir_highz,
  input  logic [N_IN-1:0]          pin_in,
  output logic [N_IN-1:0]          core_in,
  input  logic [N_GRP*GRP_W-1:0]   core_out,
  input  logic [N_GRP-1:0]         core_dis,
  output logic [N_GRP*GRP_W-1:0]   pin_out,
  output logic [N_GRP-1:0]         pin_oe,
  output logic                     tdo
);

  localparam int L = N_IN + N_GRP * (GRP_W + 1);

  function automatic logic [L-1:0] guard_vec();
    logic [L-1:0] v;
    v = '0;
    for (int g = 0; g < N_GRP; g++) v[en_idx(g, N_IN, GRP_W)] = GRP_POL[g];
    return v;
  endfunction

  localparam logic [L-1:0] GUARD = guard_vec();

  logic         sel;
  logic [L-1:0] sh_q;
  logic [L-1:0] up_q;
  logic [L-1:0] cap_d;

  assign sel = ir_extest | ir_intest | ir_sample;

  bscan_chain #(.L(L), .GUARD(GUARD)) chain_i (
    .tck    (tck),
    .trst_n (trst_n),
    .tlr    (tlr),
    .cap_en (cap_dr & sel),
    .sh_en  (shift_dr & sel),
    .upd_en (upd_dr & sel),
    .tdi    (tdi),
    .cap_d  (cap_d),
    .sh_q   (sh_q),
    .up_q   (up_q),
    .tdo    (tdo)
  );

  bscan_route #(
    .N_IN(N_IN), .N_GRP(N_GRP), .GRP_W(GRP_W), .GRP_POL(GRP_POL)
  ) route_i (
    .ir_extest (ir_extest),
    .ir_intest (ir_intest),
    .ir_highz  (ir_highz),
    .pin_in    (pin_in),
    .core_out  (core_out),
    .core_dis  (core_dis),
    .up_q      (up_q),
    .core_in   (core_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .cap_d     (cap_d)
  );

endmodule

// File: rtl/bscan_reg_chk.sv
module bscan_reg_chk #(
  parameter int           N_IN  = 4,
  parameter int           N_GRP = 2,
  parameter int           L     = 12,
  parameter logic [L-1:0] GUARD = '0
) (
  input logic             tck,
  input logic             trst_n,
  input logic             tlr,
  input logic             cap_dr,
  input logic             shift_dr,
  input logic             tdi,
  input logic             ir_extest,
  input logic             ir_intest,
  input logic             ir_sample,
  input logic             ir_highz,
  input logic [N_IN-1:0]  pin_in,
  input logic [N_IN-1:0]  core_in,
  input logic [N_GRP-1:0] pin_oe,
  input logic [L-1:0]     sh_q,
  input logic [L-1:0]     up_q
);

  logic sel, test;
  assign sel  = ir_extest | ir_intest | ir_sample;
  assign test = ir_extest | ir_intest;

  assert_shift_step_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && shift_dr && !cap_dr && !tlr) |=>
      (sh_q == {$past(sh_q[L-2:0]), $past(tdi)}));

  assert_capture_pins_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && cap_dr && !tlr) |=> (sh_q[N_IN-1:0] == $past(pin_in)));

  assert_test_holds_core_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (test && $past(test) && $stable(up_q)) |-> $stable(core_in));

  assert_highz_off_R7: assert property (@(posedge tck) disable iff (!trst_n)
    ir_highz |-> (pin_oe == '0));

  assert_normal_pass_R8: assert property (@(posedge tck) disable iff (!trst_n)
    !test |-> (core_in == pin_in));

  assert_tlr_guard_R10: assert property (@(posedge tck) disable iff (!trst_n)
    tlr |=> ((sh_q == GUARD) && (up_q == GUARD)));

  assert_idle_hold_R11: assert property (@(posedge tck) disable iff (!trst_n)
    (!sel && !tlr) |=> $stable(sh_q));

endmodule

bind bscan_reg bscan_reg_chk #(
  .N_IN(N_IN), .N_GRP(N_GRP), .L(L), .GUARD(GUARD)
) chk_i (
  .tck(tck), .trst_n(trst_n), .tlr(tlr), .cap_dr(cap_dr), .shift_dr(shift_dr),
  .tdi(tdi), .ir_extest(ir_extest), .ir_intest(ir_intest), .ir_sample(ir_sample),
  .ir_highz(ir_highz), .pin_in(pin_in), .core_in(core_in), .pin_oe(pin_oe),
  .sh_q(sh_q), .up_q(up_q)
);

// File: tb/bscan_reg_tb_top.sv
`timescale 1ns/1ps
module bscan_reg_tb_top;
  localparam int         N_IN = 4, N_GRP = 2, GRP_W = 3;
  localparam int         N_OUT = N_GRP * GRP_W;
  localparam int         L = N_IN + N_GRP * (GRP_W + 1);
  localparam logic [1:0] POL = 2'b10;

  logic tck = 1'b0, trst_n = 1'b1, tlr = 1'b0;
  logic cap_dr = 0, shift_dr = 0, upd_dr = 0, tdi = 0;
  logic ir_extest = 0, ir_intest = 0, ir_sample = 0, ir_highz = 0;
  logic [N_IN-1:0]  pin_in = '0;
  logic [N_OUT-1:0] core_out = '0;
  logic [N_GRP-1:0] core_dis = '0;
  logic [N_IN-1:0]  core_in;
  logic [N_OUT-1:0] pin_out;
  logic [N_GRP-1:0] pin_oe;
  logic             tdo;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  always #4 tck = ~tck;  // 125 MHz

  bscan_reg #(.N_IN(N_IN), .N_GRP(N_GRP), .GRP_W(GRP_W), .GRP_POL(POL)) dut_i (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .cap_dr(cap_dr), .shift_dr(shift_dr),
    .upd_dr(upd_dr), .tdi(tdi), .ir_extest(ir_extest), .ir_intest(ir_intest),
    .ir_sample(ir_sample), .ir_highz(ir_highz), .pin_in(pin_in), .core_in(core_in),
    .core_out(core_out), .core_dis(core_dis), .pin_out(pin_out), .pin_oe(pin_oe),
    .tdo(tdo)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R1 layout: inputs, then per group {enable, GRP_W outputs}
  function automatic logic [L-1:0] pack(input logic [N_IN-1:0] pi,
                                        input logic [N_GRP-1:0] dis,
                                        input logic [N_OUT-1:0] co);
    logic [L-1:0] v;
    int pos = 0;
    for (int i = 0; i < N_IN; i++) v[pos++] = pi[i];
    for (int g = 0; g < N_GRP; g++) begin
      v[pos++] = dis[g];
      for (int j = 0; j < GRP_W; j++) v[pos++] = co[g*GRP_W+j];
    end
    return v;
  endfunction

  localparam logic [L-1:0] GUARD_EXP = 12'h100;  // g0 enable cell (pos 4)=0, g1 (pos 8)=1

  // ---------------- behavioural reference model ----------------
  logic msh[$];
  logic mup[L];

  always @(posedge tck) begin
    logic [L-1:0] cv;
    logic sel;
    sel = ir_extest | ir_intest | ir_sample;
    if (!trst_n || tlr) begin
      msh.delete();
      for (int i = 0; i < L; i++) msh.push_back(GUARD_EXP[i]);
    end else if (sel && cap_dr) begin
      for (int i = 0; i < L; i++) begin
        if (i < N_IN) cv[i] = pin_in[i];
        else if (ir_extest) cv[i] = mup[i];
        else if ((i - N_IN) % (GRP_W + 1) == 0) cv[i] = core_dis[(i - N_IN) / (GRP_W + 1)];
        else cv[i] = core_out[((i - N_IN) / (GRP_W + 1)) * GRP_W + (i - N_IN) % (GRP_W + 1) - 1];
      end
      msh.delete();
      for (int i = 0; i < L; i++) msh.push_back(cv[i]);
    end else if (sel && shift_dr) begin
      msh.push_front(tdi);
      void'(msh.pop_back());
    end
  end

  always @(negedge tck) begin
    if (!trst_n || tlr) begin
      for (int i = 0; i < L; i++) mup[i] = GUARD_EXP[i];
    end else if ((ir_extest | ir_intest | ir_sample) && upd_dr) begin
      for (int i = 0; i < L; i++) mup[i] = msh[i];
    end
  end

  // compare every clock, 1 ns before the next rising edge
  always begin
    logic test, lvl;
    logic [N_IN-1:0]  e_ci;
    logic [N_OUT-1:0] e_po;
    logic [N_GRP-1:0] e_oe;
    @(posedge tck);
    #7;
    if (trst_n && !done) begin
      test = ir_extest | ir_intest;
      for (int i = 0; i < N_IN; i++) e_ci[i] = test ? mup[i] : pin_in[i];
      for (int p = 0; p < N_OUT; p++)
        e_po[p] = test ? mup[N_IN + (p / GRP_W) * (GRP_W + 1) + 1 + p % GRP_W] : core_out[p];
      for (int g = 0; g < N_GRP; g++) begin
        lvl = test ? mup[N_IN + g * (GRP_W + 1)] : core_dis[g];
        e_oe[g] = !ir_highz && (lvl !== POL[g]);
      end
      chk("R1 tdo", 64'(tdo), 64'(msh[L-1]));
      chk(test ? "R4 core_in" : "R8 core_in", 64'(core_in), 64'(e_ci));
      chk(test ? "R5 pin_out" : "R8 pin_out", 64'(pin_out), 64'(e_po));
      chk(ir_highz ? "R7 pin_oe" : (test ? "R6 pin_oe" : "R8 pin_oe"), 64'(pin_oe), 64'(e_oe));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(posedge tck);
    #2;
  endtask

  task automatic scan(input logic [L-1:0] din, output logic [L-1:0] dout);
    shift_dr = 1'b1;
    for (int k = 0; k < L; k++) begin
      tdi = din[L-1-k];
      dout[L-1-k] = tdo;
      step();
    end
    shift_dr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end

  initial begin
    logic [L-1:0] d, keep;
    #1 trst_n = 1'b0;
    repeat (3) step();
    trst_n = 1'b1;
    step();

    // R10: guard values after asynchronous reset
    ir_sample = 1'b1;
    scan('0, d);
    chk("R10 guard after trst_n", 64'(d), 64'(GUARD_EXP));

    // R2/R9: capture in sample/preload
    pin_in = 4'b1010; core_out = 6'b110101; core_dis = 2'b01;
    cap_dr = 1'b1; step(); cap_dr = 1'b0;
    scan(pack(4'b0110, 2'b11, 6'b011010), d);
    chk("R2 capture sample", 64'(d), 64'(pack(4'b1010, 2'b01, 6'b110101)));
    chk("R9 enable cell captures core disable", 64'(d[4]), 64'(1'b1));
    chk("R3 no update yet, pins follow core", 64'(pin_out), 64'(6'b110101));

    // R3..R6: update then external test
    upd_dr = 1'b1; step(); upd_dr = 1'b0;
    ir_sample = 1'b0; ir_extest = 1'b1; step();
    chk("R4 core_in from cells", 64'(core_in), 64'(4'b0110));
    chk("R5 pin_out from cells", 64'(pin_out), 64'(6'b011010));
    chk("R6 polarity, 11 loaded", 64'(pin_oe), 64'(2'b01));
    pin_in = 4'b0101; core_out = 6'b001100; core_dis = 2'b10; step();
    chk("R4 pin_in ignored", 64'(core_in), 64'(4'b0110));
    chk("R5 core_out ignored", 64'(pin_out), 64'(6'b011010));

    cap_dr = 1'b1; step(); cap_dr = 1'b0;
    scan(pack(4'b1001, 2'b00, 6'b100001), d);
    chk("R2 capture extest", 64'(d), 64'(pack(4'b0101, 2'b11, 6'b011010)));
    upd_dr = 1'b1; step(); upd_dr = 1'b0; step();
    chk("R6 polarity, 00 loaded", 64'(pin_oe), 64'(2'b10));
    chk("R3 update applied", 64'(core_in), 64'(4'b1001));
    keep = pack(4'b1001, 2'b00, 6'b100001);

    // R7/R11: high-impedance; strobes ignored
    ir_extest = 1'b0; ir_highz = 1'b1; step();
    chk("R7 all groups off", 64'(pin_oe), 64'(2'b00));
    tdi = 1'b1; shift_dr = 1'b1; repeat (3) step();
    cap_dr = 1'b1; upd_dr = 1'b1; step();
    cap_dr = 1'b0; upd_dr = 1'b0; shift_dr = 1'b0;
    ir_highz = 1'b0; ir_extest = 1'b1; step();
    chk("R11 update regs held", 64'(pin_out), 64'(6'b100001));
    ir_extest = 1'b0; ir_sample = 1'b1; step();
    scan('0, d);
    chk("R11 shift stages held", 64'(d), 64'(keep));

    // R12: internal test, capture beats shift
    ir_sample = 1'b0; ir_intest = 1'b1;
    core_out = 6'b000111; core_dis = 2'b10;
    cap_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b1; step();
    cap_dr = 1'b0; shift_dr = 1'b0;
    scan('0, d);
    chk("R12 capture wins over shift", 64'(d), 64'(pack(4'b0101, 2'b10, 6'b000111)));

    // R10: test-logic-reset
    tlr = 1'b1; cap_dr = 1'b1; step(); tlr = 1'b0; cap_dr = 1'b0; step();
    chk("R10 pins guarded", 64'(pin_out), 64'(0));
    chk("R10 core_in guarded", 64'(core_in), 64'(0));
    chk("R10 groups off", 64'(pin_oe), 64'(2'b00));
    ir_intest = 1'b0; ir_sample = 1'b1;
    scan('0, d);
    chk("R10 guard after tlr", 64'(d), 64'(GUARD_EXP));

    // R8: normal operation
    ir_sample = 1'b0;
    pin_in = 4'b1100; core_out = 6'b101010; core_dis = 2'b01; step();
    chk("R8 core_in", 64'(core_in), 64'(4'b1100));
    chk("R8 pin_out", 64'(pin_out), 64'(6'b101010));
    chk("R8 pin_oe", 64'(pin_oe), 64'(2'b11));
    core_dis = 2'b10; step();
    chk("R8 pin_oe both disabled", 64'(pin_oe), 64'(2'b00));

    step();
    done = 1;
    summary();
  end

endmodule